// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block is the write-only configuration port of a stereo audio converter. A host drives a serial clock, a data line and a load strobe. While the strobe is low, each rising serial clock edge shifts in one bit, most significant bit first. The rising edge of the strobe ends the frame. A complete frame is 16 bits: a 7-bit register address, then a 9-bit data field. The port decodes these frames into four configuration registers. The serial pins are asynchronous. They are oversampled by the system clock through a synchronizer, so every register sits in the system clock domain.

The two channel gain registers are double-buffered. A write first lands in a pending copy. Bit 8 of a gain write is a commit request and is never stored. When it is set, the pending copies of both channels move into the active gains together, on the next pulse of the audio sample strobe. The mode register and the format register take effect as soon as their frame is accepted.

The port ignores every frame while the device-ready input is low. It also drops frames of the wrong length and frames that name an address it does not decode.

Top module: `ctl3w_port`

## Requirements
- R1: A frame is accepted only at the rising edge of `cfg_load`. It is the last 16 bits shifted in on rising `cfg_sck` edges while `cfg_load` was low, most significant bit first. Word bits 15:9 are the address and bits 8:0 are the data.
- R2: After reset, both active gains are 8'hFF. Mute, de-emphasis, power-down, zero-flag combine and zero-cross disable are 0. Word length and format are 2'b10. Frame polarity, gain link, bit clock polarity and phase reverse are 0.
- R3: Address 0 writes data bits 7:0 into the pending left gain, and address 1 does the same for the right gain. When data bit 8 is 0, the active gains do not change.
- R4: When a gain write has data bit 8 set, the pending values of both channels, including the value just written, become the active gains on the first `sample_tick` pulse after the write. They do not change before that pulse.
- R5: Address 2 maps data bits as follows: bit 0 to mute, bit 1 to de-emphasis, bit 2 to power-down, bit 7 to zero-flag combine, and bit 8 to zero-cross disable.
- R6: Address 3 maps data bits as follows: bits 1:0 to word length, bits 3:2 to format, bit 4 to frame polarity, bit 5 to gain link, bit 6 to bit clock polarity, and bit 7 to phase reverse.
- R7: A frame that ends while `dev_ready` is low changes no register and no pending value.
- R8: A frame of a length other than 16 bits, or a frame addressed to 4 through 127, changes no register.
- R9: Data bits 6:3 of an address-2 write have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_ready | input | 1 | High when writes may be accepted |
| cfg_sck | input | 1 | Serial clock, asynchronous |
| cfg_sdi | input | 1 | Serial data, asynchronous |
| cfg_load | input | 1 | Frame strobe, low during shifting, rising edge commits |
| sample_tick | input | 1 | One-cycle pulse per audio sample |
| gain_l | output | 8 | Active left gain |
| gain_r | output | 8 | Active right gain |
| mute | output | 1 | Soft mute, both channels |
| deemph | output | 1 | De-emphasis enable |
| pwr_down | output | 1 | Power-down request |
| zflag_and | output | 1 | Combine zero flags of both channels |
| zc_off | output | 1 | Zero-cross detection disable |
| word_len | output | 2 | Input word length code |
| fmt_sel | output | 2 | Audio data format code |
| frame_pol | output | 1 | Frame clock polarity |
| gain_link | output | 1 | Right channel uses left gain |
| bclk_pol | output | 1 | Bit clock polarity |
| phase_rev | output | 1 | Output phase reversal |

## Verification
The bench goes after these corner cases:
- A commit request arriving on one channel while the other channel holds a pending value. A design that commits only the written channel would leave the other gain stale.
- The window between a commit request and the sample pulse. A design that commits at once would move the gains too early.
- Frames of 15 and 17 bits, and frames to undecoded addresses. A design that does not check the length or decodes too few address bits would corrupt a live register.
- Writes while not ready, and reserved mode bits set. Either would leak into the outputs of a careless decoder.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

   localparam int ADDR_GAIN_L = 0;
   localparam int ADDR_GAIN_R = 1;
   localparam int ADDR_MODE   = 2;
   localparam int ADDR_FORMAT = 3;

   // mode register data bit positions
   localparam int MB_MUTE   = 0;
   localparam int MB_DEEMPH = 1;
   localparam int MB_PWRDN  = 2;
   localparam int MB_ZAND   = 7;
   localparam int MB_ZCOFF  = 8;

   // format register data bit positions
   localparam int FB_WL     = 0;
   localparam int FB_FMT    = 2;
   localparam int FB_FPOL   = 4;
   localparam int FB_LINK   = 5;
   localparam int FB_BPOL   = 6;
   localparam int FB_REV    = 7;

   typedef struct packed {
      logic zc_off;
      logic zflag_and;
      logic pwr_down;
      logic deemph;
      logic mute;
   } mode_t;

   typedef struct packed {
      logic       phase_rev;
      logic       bclk_pol;
      logic       gain_link;
      logic       frame_pol;
      logic [1:0] fmt_sel;
      logic [1:0] word_len;
   } format_t;

   localparam mode_t   MODE_RST   = '0;
   localparam format_t FORMAT_RST = '{phase_rev: 1'b0, bclk_pol: 1'b0,
                                      gain_link: 1'b0, frame_pol: 1'b0,
                                      fmt_sel: 2'b10, word_len: 2'b10};

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ctl3w_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ctl3w_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift #(
   parameter int WORD_BITS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_clk,
   input  logic                 ser_dat,
   input  logic                 ser_load,
   output logic                 word_valid,
   output logic [WORD_BITS-1:0] word
);

   localparam int                CNT_W    = $clog2(WORD_BITS + 2);
   localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
   localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(WORD_BITS);

   if (WORD_BITS < 2) begin : g_bad_word
      $error("ctl3w_shift: WORD_BITS too small");
   end

   // bit 2 load strobe (idle high), bit 1 serial clock, bit 0 data
   logic [2:0] pins_s;
   ctl3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_load, ser_clk, ser_dat}),
      .q     (pins_s)
   );

   logic                 sck_prev, load_prev;
   logic [CNT_W-1:0]     bit_cnt;
   logic [WORD_BITS-1:0] shreg;
   logic                 sck_rise, load_rise;

   assign sck_rise  = pins_s[1] & ~sck_prev;
   assign load_rise = pins_s[2] & ~load_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev   <= 1'b0;
         load_prev  <= 1'b1;
         bit_cnt    <= '0;
         shreg      <= '0;
         word_valid <= 1'b0;
      end else begin
         sck_prev   <= pins_s[1];
         load_prev  <= pins_s[2];
         word_valid <= 1'b0;
         if (load_rise) begin
            word_valid <= (bit_cnt == CNT_FULL);
            bit_cnt    <= '0;
         end else if (!pins_s[2] && sck_rise) begin
            shreg <= {shreg[WORD_BITS-2:0], pins_s[0]};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   assign word = shreg;

   // R1: a frame yields at most one accept pulse (one strobe rise)
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R1: the shift register only moves on a serial clock rise while loading
   a_r1_shift_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !(sck_rise && !pins_s[2]) |=> $stable(shreg));

endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
   import ctl3w_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 9,
   parameter int GAIN_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       dev_ready,
   input  logic                       sample_tick,
   input  logic                       word_valid,
   input  logic [ADDR_W+DATA_W-1:0]   word,
   output logic [GAIN_W-1:0]          gain_l,
   output logic [GAIN_W-1:0]          gain_r,
   output mode_t                      mode_q,
   output format_t                    format_q
);

   localparam int WORD_BITS = ADDR_W + DATA_W;
   localparam int NCH       = 2;
   localparam int UPD_BIT   = DATA_W - 1;

   if (GAIN_W >= DATA_W) begin : g_bad_gain
      $error("ctl3w_regs: gain field must leave room for the commit bit");
   end
   if (DATA_W < 9) begin : g_bad_data
      $error("ctl3w_regs: data field too narrow for the mode register");
   end

   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;
   logic              accept;
   logic              commit_req;
   logic              commit;
   logic              pend_q;

   assign addr   = word[WORD_BITS-1 -: ADDR_W];
   assign data   = word[DATA_W-1:0];
   assign accept = word_valid & dev_ready;
   assign commit_req = accept && data[UPD_BIT] &&
                       (addr == ADDR_W'(ADDR_GAIN_L) || addr == ADDR_W'(ADDR_GAIN_R));
   assign commit = sample_tick & pend_q;

   logic [GAIN_W-1:0] pre_q [NCH];
   logic [GAIN_W-1:0] act_q [NCH];

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic hit;
      assign hit = accept && (addr == ADDR_W'(ch));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q[ch] <= '1;
            act_q[ch] <= '1;
         end else begin
            if (hit)    pre_q[ch] <= data[GAIN_W-1:0];
            if (commit) act_q[ch] <= pre_q[ch];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (commit_req) pend_q <= 1'b1;
      else if (commit)     pend_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_RST;
         format_q <= FORMAT_RST;
      end else if (accept) begin
         if (addr == ADDR_W'(ADDR_MODE)) begin
            mode_q.mute      <= data[MB_MUTE];
            mode_q.deemph    <= data[MB_DEEMPH];
            mode_q.pwr_down  <= data[MB_PWRDN];
            mode_q.zflag_and <= data[MB_ZAND];
            mode_q.zc_off    <= data[MB_ZCOFF];
         end
         if (addr == ADDR_W'(ADDR_FORMAT)) begin
            format_q.word_len  <= data[FB_WL +: 2];
            format_q.fmt_sel   <= data[FB_FMT +: 2];
            format_q.frame_pol <= data[FB_FPOL];
            format_q.gain_link <= data[FB_LINK];
            format_q.bclk_pol  <= data[FB_BPOL];
            format_q.phase_rev <= data[FB_REV];
         end
      end
   end

   assign gain_l = act_q[0];
   assign gain_r = act_q[1];

   a_r7_ignore_unready: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_ready |=> $stable(mode_q) && $stable(format_q) &&
                     $stable(pre_q[0]) && $stable(pre_q[1]));

   a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(act_q[0]) && $stable(act_q[1]));

   a_r4_both_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && pend_q) |=> (act_q[0] == $past(pre_q[0])) &&
                                  (act_q[1] == $past(pre_q[1])));

   a_r8_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && addr > ADDR_W'(ADDR_FORMAT)) |=>
         $stable(mode_q) && $stable(format_q) &&
         $stable(pre_q[0]) && $stable(pre_q[1]));

endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
   import ctl3w_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 9,
   parameter int GAIN_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_ready,
   input  logic              cfg_sck,
   input  logic              cfg_sdi,
   input  logic              cfg_load,
   input  logic              sample_tick,
   output logic [GAIN_W-1:0] gain_l,
   output logic [GAIN_W-1:0] gain_r,
   output logic              mute,
   output logic              deemph,
   output logic              pwr_down,
   output logic              zflag_and,
   output logic              zc_off,
   output logic [1:0]        word_len,
   output logic [1:0]        fmt_sel,
   output logic              frame_pol,
   output logic              gain_link,
   output logic              bclk_pol,
   output logic              phase_rev
);

   localparam int WORD_BITS = ADDR_W + DATA_W;

   logic                 word_valid;
   logic [WORD_BITS-1:0] word;
   mode_t                mode_q;
   format_t              format_q;

   ctl3w_shift #(.WORD_BITS(WORD_BITS), .SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_clk    (cfg_sck),
      .ser_dat    (cfg_sdi),
      .ser_load   (cfg_load),
      .word_valid (word_valid),
      .word       (word)
   );

   ctl3w_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .dev_ready   (dev_ready),
      .sample_tick (sample_tick),
      .word_valid  (word_valid),
      .word        (word),
      .gain_l      (gain_l),
      .gain_r      (gain_r),
      .mode_q      (mode_q),
      .format_q    (format_q)
   );

   assign mute      = mode_q.mute;
   assign deemph    = mode_q.deemph;
   assign pwr_down  = mode_q.pwr_down;
   assign zflag_and = mode_q.zflag_and;
   assign zc_off    = mode_q.zc_off;
   assign word_len  = format_q.word_len;
   assign fmt_sel   = format_q.fmt_sel;
   assign frame_pol = format_q.frame_pol;
   assign gain_link = format_q.gain_link;
   assign bclk_pol  = format_q.bclk_pol;
   assign phase_rev = format_q.phase_rev;

endmodule

// File: tb/tb_ctl3w_port.sv
module tb_ctl3w_port;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dev_ready = 1'b0;
   logic cfg_sck = 1'b0;
   logic cfg_sdi = 1'b0;
   logic cfg_load = 1'b1;
   logic sample_tick = 1'b0;
   logic [7:0] gain_l, gain_r;
   logic mute, deemph, pwr_down, zflag_and, zc_off;
   logic [1:0] word_len, fmt_sel;
   logic frame_pol, gain_link, bclk_pol, phase_rev;

   always #5 clk = ~clk;

   ctl3w_port dut (
      .clk(clk), .rst_n(rst_n), .dev_ready(dev_ready),
      .cfg_sck(cfg_sck), .cfg_sdi(cfg_sdi), .cfg_load(cfg_load),
      .sample_tick(sample_tick),
      .gain_l(gain_l), .gain_r(gain_r), .mute(mute), .deemph(deemph),
      .pwr_down(pwr_down), .zflag_and(zflag_and), .zc_off(zc_off),
      .word_len(word_len), .fmt_sel(fmt_sel), .frame_pol(frame_pol),
      .gain_link(gain_link), .bclk_pol(bclk_pol), .phase_rev(phase_rev)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // model state
   logic [7:0] m_pre_l, m_pre_r, m_act_l, m_act_r;
   logic       m_pend;
   logic [4:0] m_mode;   // {zc_off, zflag_and, pwr_down, deemph, mute}
   logic [7:0] m_fmt;    // {rev, bpol, link, fpol, fmt[1:0], wl[1:0]}

   function automatic logic [28:0] exp_vec();
      return {m_act_l, m_act_r, m_mode, m_fmt};
   endfunction

   function automatic logic [28:0] dut_vec();
      return {gain_l, gain_r, zc_off, zflag_and, pwr_down, deemph, mute,
              phase_rev, bclk_pol, gain_link, frame_pol, fmt_sel, word_len};
   endfunction

   task automatic model_reset();
      m_pre_l = 8'hFF; m_pre_r = 8'hFF; m_act_l = 8'hFF; m_act_r = 8'hFF;
      m_pend = 1'b0; m_mode = 5'b0; m_fmt = 8'b0000_1010;
   endtask

   task automatic model_write(input logic [15:0] w, input int nbits, input logic rdy);
      logic [6:0] a;
      logic [8:0] d;
      a = w[15:9];
      d = w[8:0];
      if (nbits != 16 || !rdy) return;
      case (a)
         7'd0: begin m_pre_l = d[7:0]; if (d[8]) m_pend = 1'b1; end
         7'd1: begin m_pre_r = d[7:0]; if (d[8]) m_pend = 1'b1; end
         7'd2: m_mode = {d[8], d[7], d[2], d[1], d[0]};
         7'd3: m_fmt = d[7:0];
         default: ;
      endcase
   endtask

   task automatic check(input string req);
      checks++;
      if (dut_vec() !== exp_vec()) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, dut_vec(), exp_vec());
      end
   endtask

   task automatic frame(input logic [15:0] w, input int nbits);
      @(negedge clk);
      cfg_load = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         cfg_sdi = (i < 16) ? w[15-i] : 1'b0;
         cfg_sck = 1'b0;
         repeat (3) @(negedge clk);
         cfg_sck = 1'b1;
         repeat (3) @(negedge clk);
      end
      cfg_sck = 1'b0;
      repeat (3) @(negedge clk);
      cfg_load = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic write(input logic [15:0] w, input int nbits);
      frame(w, nbits);
      model_write(w, nbits, dev_ready);
   endtask

   task automatic tick();
      @(negedge clk);
      sample_tick = 1'b1;
      @(negedge clk);
      sample_tick = 1'b0;
      if (m_pend) begin
         m_act_l = m_pre_l; m_act_r = m_pre_r; m_pend = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [15:0] mk(input int a, input logic [8:0] d);
      return {7'(a), d};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2417));
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R2 reset values");

      // R7: not ready, writes ignored
      write(mk(2, 9'h1FF), 16);
      write(mk(0, 9'h112), 16);
      tick();
      check("R7 write while not ready");
      dev_ready = 1'b1;

      // R5 mode fields, R9 reserved bits
      write(mk(2, 9'h078), 16);
      check("R9 reserved mode bits");
      write(mk(2, 9'h187), 16);
      check("R5 mode fields set");
      write(mk(2, 9'h002), 16);
      check("R5 mode fields mixed");

      // R6 format fields
      write(mk(3, 9'h0B5), 16);
      check("R6 format fields");
      write(mk(3, 9'h14A), 16);
      check("R6 format fields second pattern");

      // R3 pre-latch only, R4 commit both
      write(mk(0, 9'h033), 16);
      tick();
      check("R3 no update keeps active gain");
      write(mk(1, 9'h1C4), 16);
      check("R4 no change before sample");
      tick();
      check("R4 both channels commit on sample");
      write(mk(1, 9'h1AA), 16);
      write(mk(0, 9'h055), 16);
      tick();
      check("R4 commit includes later pre-latch");

      // R8 wrong length and undecoded address
      write(mk(2, 9'h1FF), 15);
      check("R8 short frame dropped");
      write(mk(2, 9'h1FF), 17);
      check("R8 long frame dropped");
      write(mk(5, 9'h1FF), 16);
      write(mk(66, 9'h1FF), 16);
      write(mk(127, 9'h1FF), 16);
      tick();
      check("R8 undecoded address dropped");

      // R1: bit order check through a single-bit pattern
      write(mk(0, 9'h180), 16);
      tick();
      check("R1 msb-first bit order");

      // random mix
      for (int it = 0; it < 70; it++) begin
         int a, r;
         logic [8:0] d;
         a = $urandom_range(0, 5);
         if (a == 5) a = $urandom_range(4, 127);
         d = 9'($urandom);
         r = $urandom_range(0, 11);
         @(negedge clk);
         dev_ready = ($urandom_range(0, 9) != 0);
         write(mk(a, d), (r == 0) ? 15 : (r == 1) ? 17 : 16);
         if ($urandom_range(0, 1) == 1) tick();
         check("R1 R3 R4 R5 R6 R7 R8 random frame");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule